// File: doc/BRIEF.md
# Raster LCD Timing Signal Generator

This block turns a free-running internal clock into the timing pins of a raster LCD panel: a pixel clock, a line sync, a frame sync, a line load strobe and a 24-bit pixel data bus. A position counter walks through each line and then each frame. A small sequencer sorts every pixel into one of three classes: visible, line blanking or frame blanking. One output stage registers every pin and applies gating, zero-forcing and a per-pin polarity select. It does this on a single clock edge, so all pins change together.

Every pixel period lasts two internal clock cycles. In the first cycle the raw pixel clock is low and in the second it is high, so the panel can latch data on the rising edge in the middle of the period. The sequencer has four named states: `ST_STOP` (halted), `ST_ACTIVE` (a visible pixel), `ST_HBLANK` (past the visible part of a visible line) and `ST_VBLANK` (a line below the visible area). It makes these transitions:
- STOP → ACTIVE when the run bit is seen high.
- ACTIVE, HBLANK or VBLANK → STOP as soon as the run bit is low.
- At the end of every pixel period, a running state moves to the class of the next position: ACTIVE, HBLANK or VBLANK.

The timing counts (visible pixels, total pixels, visible lines, total lines) are set by the user. They must satisfy 1 ≤ visible < total, and they must be held steady while the block runs. A pixel carries valid data when it lies in the visible area and the data source raises its valid input in that clock cycle. The polarity inputs should be tied to the panel's needs; the levels the pins take in reset match the default polarity settings (pixel clock inverted, frame sync inverted, line sync and load normal).

Top module: `lcd_raster_timer`

## Requirements
- R1: While `run_en` is low the block is halted. From the second clock edge after `run_en` is seen low, each timing pin rests at its inactive level (equal to its polarity input) and `lcd_data` is 0.
- R2: Each time `run_en` rises, the position restarts at pixel 0 of line 0. On the second clock edge after the rise, the pins show that pixel (line sync and frame sync both active).
- R3: A pixel period is two clock cycles, with the raw pixel clock low in the first and high in the second. With `pclk_gate`=0 and `stn_mode`=0 it toggles on every pixel.
- R4: With `pclk_gate`=1 the raw pixel clock goes high only in the second cycle of a pixel that carries valid data, and stays low otherwise.
- R5: With `stn_mode`=1 the pixel clock is gated as in R4, whatever the value of `pclk_gate`.
- R6: Each pin is its raw active-high value XOR its own polarity bit. A polarity bit of 0 gives the normal sense and 1 gives the inverted sense. The four pins are `pol_pclk`, `pol_hs`, `pol_vs` and `pol_ld`.
- R7: During reset the pins are `lcd_pclk`=1, `lcd_hsync`=0, `lcd_vsync`=1, `lcd_load`=0 and `lcd_data`=0.
- R8: The raw line sync is active for the whole of pixel 0 of every line, including lines in frame blanking.
- R9: The raw frame sync is active for the first N lines of each frame. `vs_width` codes 0, 1 and 2 give N = 1, 2 and 3. The reserved code 3 gives N = 3.
- R10: With `zero_data`=1, `lcd_data` is 0 and every timing pin keeps its usual waveform.
- R11: With `load_mode`=0 the raw load strobe is active on pixels `h_active` up to `h_active+load_width-1` of every line, cut off at the end of the line. With `load_mode`=1 it is active exactly on pixels that carry valid data.
- R12: Pixel data is valid when the position is inside the visible area and `src_valid` is high. `lcd_data` then carries `pix_in`; at every other position it is 0. All pins are registered one clock after the position they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; two cycles per pixel |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run bit; 0 halts all timing |
| pclk_gate | input | 1 | 1 = pixel clock only on valid data |
| stn_mode | input | 1 | Panel type: 1 = STN (forces gating), 0 = TFT |
| zero_data | input | 1 | 1 = data bus forced to 0 |
| load_mode | input | 1 | Load strobe source: 0 = count, 1 = valid data |
| vs_width | input | 2 | Frame sync width code in lines |
| load_width | input | CW | Load strobe width in pixels when `load_mode`=0 |
| h_active | input | CW | Visible pixels per line |
| h_total | input | CW | Total pixels per line |
| v_active | input | CW | Visible lines per frame |
| v_total | input | CW | Total lines per frame |
| pol_pclk | input | 1 | Pixel clock polarity |
| pol_hs | input | 1 | Line sync polarity |
| pol_vs | input | 1 | Frame sync polarity |
| pol_ld | input | 1 | Load strobe polarity |
| src_valid | input | 1 | Data source has a pixel this cycle |
| pix_in | input | DW | Pixel data from the source |
| lcd_pclk | output | 1 | Pixel clock pin |
| lcd_hsync | output | 1 | Line sync pin |
| lcd_vsync | output | 1 | Frame sync pin |
| lcd_load | output | 1 | Line load strobe pin |
| lcd_data | output | DW | Pixel data bus |

## Verification
The bench builds the block with a 10-bit count width and the default 24-bit data width. It programs a raster of 7 pixels by 5 lines, with 4 visible pixels and 3 visible lines. One frame therefore takes only 70 clock cycles. This makes it practical to cover many complete frames: line wraps, frame wraps, every frame sync width code, and a load window wide enough to be cut off at the end of the line. A short `src_valid` gap pattern creates valid-data holes inside the visible area, so the gated pixel clock, the STN override and the data-driven load strobe are all exercised.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HBLANK = 2'd2,
        ST_VBLANK = 2'd3
    } scan_state_e;

    // Pin levels held in reset (match the default polarity selections)
    localparam logic RST_PCLK = 1'b1;
    localparam logic RST_HS   = 1'b0;
    localparam logic RST_VS   = 1'b1;
    localparam logic RST_LD   = 1'b0;

    // Frame sync width code to line count; reserved code maps to 3
    function automatic logic [1:0] vs_lines(input logic [1:0] code);
        logic [1:0] n;
        unique case (code)
            2'd0:    n = 2'd1;
            2'd1:    n = 2'd2;
            default: n = 2'd3;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          running,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] h_q,
    output logic [CW-1:0] v_q,
    output logic          ph_q,
    output logic [CW-1:0] nxt_h,
    output logic [CW-1:0] nxt_v,
    output logic          px_end
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic line_wrap;

    always_comb begin
        px_end    = running & ph_q;
        line_wrap = (h_q == h_total - ONE);
        nxt_h     = line_wrap ? '0 : h_q + ONE;
        if (line_wrap)
            nxt_v = (v_q == v_total - ONE) ? '0 : v_q + ONE;
        else
            nxt_v = v_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q  <= '0;
            v_q  <= '0;
            ph_q <= 1'b0;
        end else if (!run_en) begin
            h_q  <= '0;
            v_q  <= '0;
            ph_q <= 1'b0;
        end else if (running) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                h_q <= nxt_h;
                v_q <= nxt_v;
            end
        end
    end

    // R2: halting clears the position
    a_r2_position_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (h_q == '0 && v_q == '0 && !ph_q));

    // R3: the half-pixel phase alternates every cycle while running
    a_r3_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en) |=> (ph_q != $past(ph_q)));

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
    import lcd_tg_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          px_end,
    input  logic [CW-1:0] nxt_h,
    input  logic [CW-1:0] nxt_v,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] v_active,
    output scan_state_e   state_q,
    output logic          running,
    output logic          in_active
);

    scan_state_e state_d;
    scan_state_e nxt_class;

    always_comb begin
        if (nxt_v >= v_active)
            nxt_class = ST_VBLANK;
        else if (nxt_h >= h_active)
            nxt_class = ST_HBLANK;
        else
            nxt_class = ST_ACTIVE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run_en)
                    state_d = ST_ACTIVE;
            end
            ST_ACTIVE, ST_HBLANK, ST_VBLANK: begin
                if (!run_en)
                    state_d = ST_STOP;
                else if (px_end)
                    state_d = nxt_class;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    always_comb begin
        running   = (state_q != ST_STOP);
        in_active = (state_q == ST_ACTIVE);
    end

    // R1: a low run bit halts the sequencer on the next edge
    a_r1_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_STOP));

    // R2: starting always enters the first visible pixel
    a_r2_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && run_en) |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
    import lcd_tg_pkg::*;
#(
    parameter int CW = 10,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          in_active,
    input  logic          src_valid,
    input  logic          ph,
    input  logic [CW-1:0] h_pos,
    input  logic [CW-1:0] v_pos,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] load_width,
    input  logic [1:0]    vs_width,
    input  logic          pclk_gate,
    input  logic          stn_mode,
    input  logic          zero_data,
    input  logic          load_mode,
    input  logic          pol_pclk,
    input  logic          pol_hs,
    input  logic          pol_vs,
    input  logic          pol_ld,
    input  logic [DW-1:0] pix_in,
    output logic          pclk_o,
    output logic          hs_o,
    output logic          vs_o,
    output logic          ld_o,
    output logic [DW-1:0] data_o
);

    logic          vld;
    logic          gated;
    logic          raw_pclk;
    logic          raw_hs;
    logic          raw_vs;
    logic          raw_ld;
    logic          in_ld_win;
    logic [CW:0]   ld_end;
    logic [DW-1:0] data_d;

    always_comb begin
        vld       = running & in_active & src_valid;
        gated     = stn_mode | pclk_gate;
        raw_pclk  = running & ph & (~gated | vld);
        raw_hs    = running & (h_pos == '0);
        raw_vs    = running & (v_pos < CW'(vs_lines(vs_width)));
        ld_end    = {1'b0, h_active} + {1'b0, load_width};
        in_ld_win = ({1'b0, h_pos} >= {1'b0, h_active}) && ({1'b0, h_pos} < ld_end);
        raw_ld    = running & (load_mode ? vld : in_ld_win);
        data_d    = (vld && !zero_data) ? pix_in : '0;
    end

    // Polarity is folded into the final register so every pin moves on one edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_o <= RST_PCLK;
            hs_o   <= RST_HS;
            vs_o   <= RST_VS;
            ld_o   <= RST_LD;
            data_o <= '0;
        end else begin
            pclk_o <= raw_pclk ^ pol_pclk;
            hs_o   <= raw_hs ^ pol_hs;
            vs_o   <= raw_vs ^ pol_vs;
            ld_o   <= raw_ld ^ pol_ld;
            data_o <= data_d;
        end
    end

    // R1: no data leaves the block while halted
    a_r1_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (data_o == '0));

    // R5: STN panels never see a pixel clock edge outside valid data
    a_r5_stn_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (stn_mode && !(in_active && src_valid)) |=> (pclk_o == $past(pol_pclk)));

    // R10: forced-zero data empties the bus
    a_r10_zero_bus: assert property (@(posedge clk) disable iff (!rst_n)
        zero_data |=> (data_o == '0));

    // R8: line sync is inactive away from pixel 0
    a_r8_hs_only_pixel0: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |=> (hs_o == $past(pol_hs)));

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_tg_pkg::*;
#(
    parameter int CW = 10,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          pclk_gate,
    input  logic          stn_mode,
    input  logic          zero_data,
    input  logic          load_mode,
    input  logic [1:0]    vs_width,
    input  logic [CW-1:0] load_width,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_active,
    input  logic [CW-1:0] v_total,
    input  logic          pol_pclk,
    input  logic          pol_hs,
    input  logic          pol_vs,
    input  logic          pol_ld,
    input  logic          src_valid,
    input  logic [DW-1:0] pix_in,
    output logic          lcd_pclk,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_load,
    output logic [DW-1:0] lcd_data
);

    scan_state_e   state_q;
    logic          running;
    logic          in_active;
    logic [CW-1:0] h_q;
    logic [CW-1:0] v_q;
    logic          ph_q;
    logic [CW-1:0] nxt_h;
    logic [CW-1:0] nxt_v;
    logic          px_end;

    lcd_scan_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .running (running),
        .h_total (h_total),
        .v_total (v_total),
        .h_q     (h_q),
        .v_q     (v_q),
        .ph_q    (ph_q),
        .nxt_h   (nxt_h),
        .nxt_v   (nxt_v),
        .px_end  (px_end)
    );

    lcd_seq_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .px_end    (px_end),
        .nxt_h     (nxt_h),
        .nxt_v     (nxt_v),
        .h_active  (h_active),
        .v_active  (v_active),
        .state_q   (state_q),
        .running   (running),
        .in_active (in_active)
    );

    lcd_out_stage #(.CW(CW), .DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .in_active  (in_active),
        .src_valid  (src_valid),
        .ph         (ph_q),
        .h_pos      (h_q),
        .v_pos      (v_q),
        .h_active   (h_active),
        .load_width (load_width),
        .vs_width   (vs_width),
        .pclk_gate  (pclk_gate),
        .stn_mode   (stn_mode),
        .zero_data  (zero_data),
        .load_mode  (load_mode),
        .pol_pclk   (pol_pclk),
        .pol_hs     (pol_hs),
        .pol_vs     (pol_vs),
        .pol_ld     (pol_ld),
        .pix_in     (pix_in),
        .pclk_o     (lcd_pclk),
        .hs_o       (lcd_hsync),
        .vs_o       (lcd_vsync),
        .ld_o       (lcd_load),
        .data_o     (lcd_data)
    );

    // R12: data only appears while the sequencer reports a visible pixel
    a_r12_data_visible_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE) |=> (lcd_data == '0));

endmodule

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;

    localparam int CW     = 10;
    localparam int DW     = 24;
    localparam int CLK_NS = 10;
    localparam int HACT   = 4;
    localparam int HTOT   = 7;
    localparam int VACT   = 3;
    localparam int VTOT   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          pclk_gate = 1'b0;
    logic          stn_mode = 1'b0;
    logic          zero_data = 1'b0;
    logic          load_mode = 1'b0;
    logic [1:0]    vs_width = 2'd0;
    logic [CW-1:0] load_width = CW'(2);
    logic [CW-1:0] h_active = CW'(HACT);
    logic [CW-1:0] h_total = CW'(HTOT);
    logic [CW-1:0] v_active = CW'(VACT);
    logic [CW-1:0] v_total = CW'(VTOT);
    logic          pol_pclk = 1'b1;
    logic          pol_hs = 1'b0;
    logic          pol_vs = 1'b1;
    logic          pol_ld = 1'b0;
    logic          src_valid = 1'b1;
    logic [DW-1:0] pix_in = '0;
    logic          lcd_pclk;
    logic          lcd_hsync;
    logic          lcd_vsync;
    logic          lcd_load;
    logic [DW-1:0] lcd_data;

    int checks = 0;
    int errors = 0;
    int tick = 0;
    bit cmp_en = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    lcd_raster_timer #(.CW(CW), .DW(DW)) u_lcd_raster_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pclk_gate(pclk_gate),
        .stn_mode(stn_mode), .zero_data(zero_data), .load_mode(load_mode),
        .vs_width(vs_width), .load_width(load_width), .h_active(h_active),
        .h_total(h_total), .v_active(v_active), .v_total(v_total),
        .pol_pclk(pol_pclk), .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_ld(pol_ld),
        .src_valid(src_valid), .pix_in(pix_in), .lcd_pclk(lcd_pclk),
        .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_load(lcd_load),
        .lcd_data(lcd_data)
    );

    // Behavioural reference: position, run flag and expected pins
    bit            m_run;
    int            m_h;
    int            m_v;
    int            m_ph;
    logic          e_pclk, e_hs, e_vs, e_ld;
    logic [DW-1:0] e_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_h = 0; m_v = 0; m_ph = 0;
            e_pclk = 1'b1; e_hs = 1'b0; e_vs = 1'b1; e_ld = 1'b0; e_data = '0;
        end else begin
            bit vld, rp, rh, rv, rl;
            int nlines;
            vld    = m_run && (m_h < HACT) && (m_v < VACT) && src_valid;
            rp     = m_run && (m_ph == 1) && (!(stn_mode || pclk_gate) || vld);
            rh     = m_run && (m_h == 0);
            nlines = (vs_width == 2'd0) ? 1 : (vs_width == 2'd1) ? 2 : 3;
            rv     = m_run && (m_v < nlines);
            rl     = m_run && (load_mode ? vld
                              : (m_h >= HACT && m_h < HACT + int'(load_width)));
            e_pclk = rp ^ pol_pclk;
            e_hs   = rh ^ pol_hs;
            e_vs   = rv ^ pol_vs;
            e_ld   = rl ^ pol_ld;
            e_data = (vld && !zero_data) ? pix_in : '0;
            if (!run_en) begin
                m_run = 0; m_h = 0; m_v = 0; m_ph = 0;
            end else if (!m_run) begin
                m_run = 1;
            end else if (m_ph == 0) begin
                m_ph = 1;
            end else begin
                m_ph = 0;
                m_h  = m_h + 1;
                if (m_h == HTOT) begin
                    m_h = 0;
                    m_v = m_v + 1;
                    if (m_v == VTOT) m_v = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_en) begin
            check(lcd_pclk == e_pclk, "R3 R4 R5 R6 pclk", 32'(lcd_pclk), 32'(e_pclk));
            check(lcd_hsync == e_hs, "R8 R6 hsync", 32'(lcd_hsync), 32'(e_hs));
            check(lcd_vsync == e_vs, "R9 R6 vsync", 32'(lcd_vsync), 32'(e_vs));
            check(lcd_load == e_ld, "R11 R6 load", 32'(lcd_load), 32'(e_ld));
            check(lcd_data == e_data, "R10 R12 data", 32'(lcd_data), 32'(e_data));
        end
    end

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick++;
            src_valid = ((tick % 9) != 4) && ((tick % 13) != 7);
            pix_in    = {8'hA5, 16'(tick * 37)};
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset levels
        check(lcd_pclk == 1'b1 && lcd_hsync == 1'b0 && lcd_vsync == 1'b1 &&
              lcd_load == 1'b0 && lcd_data == '0, "R7 reset levels",
              {lcd_data[27-DW+4:0], lcd_pclk, lcd_hsync, lcd_vsync, lcd_load},
              32'b1010);
        rst_n  = 1'b1;
        cmp_en = 1'b1;
        run_cycles(4);

        // TFT, continuous clock, normal polarities, count-based load
        pol_pclk = 1'b0; pol_vs = 1'b0;
        run_en = 1'b1;
        run_cycles(150);
        // R4 gated clock
        pclk_gate = 1'b1;
        run_cycles(150);
        // R5 STN forces gating even with the gate bit clear
        pclk_gate = 1'b0; stn_mode = 1'b1;
        run_cycles(150);
        stn_mode = 1'b0;
        // R6 all pins inverted, R9 wider frame sync codes
        pol_pclk = 1'b1; pol_hs = 1'b1; pol_vs = 1'b1; pol_ld = 1'b1;
        vs_width = 2'd1;
        run_cycles(150);
        vs_width = 2'd2;
        run_cycles(150);
        vs_width = 2'd3;
        run_cycles(150);
        pol_hs = 1'b0; pol_ld = 1'b0;
        // R10 forced zero data
        zero_data = 1'b1;
        run_cycles(150);
        zero_data = 1'b0;
        // R11 window cut at line end, then data-driven load
        load_width = CW'(5);
        run_cycles(150);
        load_mode = 1'b1;
        run_cycles(150);

        // R1: halt mid-frame
        run_cycles(23);
        run_en = 1'b0;
        run_cycles(2);
        check(lcd_pclk == pol_pclk && lcd_hsync == pol_hs && lcd_vsync == pol_vs &&
              lcd_load == pol_ld && lcd_data == '0, "R1 halted pins",
              {28'd0, lcd_pclk, lcd_hsync, lcd_vsync, lcd_load},
              {28'd0, pol_pclk, pol_hs, pol_vs, pol_ld});
        run_cycles(20);
        check(lcd_hsync == pol_hs && lcd_vsync == pol_vs, "R1 still halted",
              {30'd0, lcd_hsync, lcd_vsync}, {30'd0, pol_hs, pol_vs});

        // R2: restart at line 0 pixel 0
        run_en = 1'b1;
        run_cycles(2);
        check(lcd_hsync == ~pol_hs && lcd_vsync == ~pol_vs, "R2 restart at origin",
              {30'd0, lcd_hsync, lcd_vsync}, {30'd0, ~pol_hs, ~pol_vs});
        run_cycles(200);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule